// File: doc/BRIEF.md
# Serial-Clocked Wiper Step Controller

This block runs the stepping mode of a multi-channel digital potentiometer. The command decoder arms it once the instruction byte for a step command has been acknowledged and gives it a channel index. From then on the block follows the two-wire bus. At every rising edge of the serial clock it samples the data line. When the clock falls again it moves the armed channel's wiper register one position. A high data level moves the wiper up and a low level moves it down. Any mix of up and down pulses may follow, and the mode lasts until the bus shows a START or a STOP.

The block receives edge strobes and levels that have already been synchronised and detected: clock rise, clock fall, START, STOP and the data level. It also receives the present value of every wiper register. For each step it returns a single-cycle update strobe with the channel number and the new value, and the external wiper storage applies it. The block only writes wiper values. It does not touch the stored data registers, and it never drives the data line.

Top module: `wiper_step_ctrl`

## Requirements
- R1: After reset `step_active` and `upd_vld` are 0.
- R2: A cycle with `arm` high and neither `start_det` nor `stop_det` high sets `step_active` in the next cycle and latches `arm_chan` as the step channel.
- R3: While active, an SCL rise with `sda_lvl`=1 followed by an SCL fall raises `upd_vld` for one cycle, one cycle after the fall cycle. `upd_val` is the channel's wiper plus one and `upd_chan` is the armed channel.
- R4: The same pulse with `sda_lvl`=0 at the rise gives the wiper minus one.
- R5: The wiper saturates. An up step from all-ones and a down step from zero still strobe, and they return the unchanged value with no wraparound.
- R6: In one active period any mix of up and down pulses is allowed, and each completed pulse gives exactly one strobe. Only the armed channel's wiper changes.
- R7: `stop_det` clears `step_active` in the next cycle. No SCL pulse after that gives a strobe until the block is armed again.
- R8: `start_det` ends the mode in the same way as `stop_det`. A START or STOP that arrives between an SCL rise and its fall cancels that pending step.
- R9: While not active, SCL pulses give no strobe. The direction is taken only at the SCL rise, so a change of `sda_lvl` between the rise and the fall has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_rise | input | 1 | Strobe: serial clock rising edge seen |
| scl_fall | input | 1 | Strobe: serial clock falling edge seen |
| sda_lvl | input | 1 | Synchronised serial data level |
| start_det | input | 1 | Strobe: START condition seen |
| stop_det | input | 1 | Strobe: STOP condition seen |
| arm | input | 1 | Strobe: step command acknowledged |
| arm_chan | input | CH_W | Channel addressed by the step command |
| wiper_all | input | NUM_CH*WIPER_W | Present wiper values, channel 0 in the low bits |
| step_active | output | 1 | Step mode is running |
| upd_vld | output | 1 | Update strobe for the wiper storage |
| upd_chan | output | CH_W | Channel to update |
| upd_val | output | WIPER_W | New wiper value |

## Verification
Each update strobe is due exactly one clock after the cycle that carries the SCL fall strobe, because only the output register lies between the two. `step_active` changes one clock after `arm`, `start_det` or `stop_det`. The driver pushes the expected channel and value into the scoreboard in the same cycle that it raises the fall strobe. The monitor samples on the falling clock edge and pops an item only when it sees `upd_vld`, so a strobe that is late, missing or unexpected shows up as an unmatched or leftover item. Every mode check is taken one full cycle after the strobe that causes it.

// File: rtl/wiper_step_pkg.sv
package wiper_step_pkg;
   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } step_dir_e;
endpackage

// File: rtl/wiper_step_sel.sv
module wiper_step_sel #(
   parameter int WIPER_W = 8,
   parameter int NUM_CH  = 4,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic [NUM_CH*WIPER_W-1:0] wiper_all,
   input  logic [CH_W-1:0]           chan,
   output logic [WIPER_W-1:0]        cur_val
);
   generate
      if (NUM_CH == 1) begin : g_single
         logic unused_chan;
         assign unused_chan = ^chan;
         assign cur_val = wiper_all;
      end else begin : g_multi
         logic [WIPER_W-1:0] slice [NUM_CH];
         for (genvar i = 0; i < NUM_CH; i++) begin : g_slice
            assign slice[i] = wiper_all[i*WIPER_W +: WIPER_W];
         end
         always_comb begin
            cur_val = '0;
            for (int k = 0; k < NUM_CH; k++) begin
               if (chan == CH_W'(k)) cur_val = slice[k];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/wiper_step_seq.sv
module wiper_step_seq
   import wiper_step_pkg::*;
#(
   parameter int NUM_CH = 4,
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            sda_lvl,
   input  logic            start_det,
   input  logic            stop_det,
   input  logic            arm,
   input  logic [CH_W-1:0] arm_chan,
   output logic            active,
   output logic [CH_W-1:0] chan,
   output logic            fire,
   output step_dir_e       dir
);
   logic bus_break;
   logic pend;

   assign bus_break = start_det | stop_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         chan   <= '0;
         pend   <= 1'b0;
         dir    <= DIR_DOWN;
      end else if (bus_break) begin
         active <= 1'b0;
         pend   <= 1'b0;
      end else if (arm) begin
         active <= 1'b1;
         chan   <= arm_chan;
         pend   <= 1'b0;
      end else if (active) begin
         if (scl_rise) begin
            pend <= 1'b1;
            dir  <= sda_lvl ? DIR_UP : DIR_DOWN;
         end else if (scl_fall) begin
            pend <= 1'b0;
         end
      end
   end

   assign fire = active & pend & scl_fall & ~bus_break & ~arm;
endmodule

// File: rtl/wiper_step_calc.sv
module wiper_step_calc
   import wiper_step_pkg::*;
#(
   parameter int WIPER_W = 8,
   parameter int NUM_CH  = 4,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
   localparam logic [WIPER_W-1:0] TOP_VAL = {WIPER_W{1'b1}}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fire,
   input  step_dir_e          dir,
   input  logic [CH_W-1:0]    chan,
   input  logic [WIPER_W-1:0] cur_val,
   output logic               upd_vld,
   output logic [CH_W-1:0]    upd_chan,
   output logic [WIPER_W-1:0] upd_val
);
   logic [WIPER_W-1:0] next_val;

   always_comb begin
      next_val = cur_val;
      if (dir == DIR_UP) begin
         if (cur_val != TOP_VAL) next_val = cur_val + 1'b1;
      end else begin
         if (cur_val != '0) next_val = cur_val - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         upd_vld  <= 1'b0;
         upd_chan <= '0;
         upd_val  <= '0;
      end else begin
         upd_vld <= fire;
         if (fire) begin
            upd_chan <= chan;
            upd_val  <= next_val;
         end
      end
   end
endmodule

// File: rtl/wiper_step_ctrl.sv
module wiper_step_ctrl
   import wiper_step_pkg::*;
#(
   parameter int WIPER_W = 8,
   parameter int NUM_CH  = 4,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      scl_rise,
   input  logic                      scl_fall,
   input  logic                      sda_lvl,
   input  logic                      start_det,
   input  logic                      stop_det,
   input  logic                      arm,
   input  logic [CH_W-1:0]           arm_chan,
   input  logic [NUM_CH*WIPER_W-1:0] wiper_all,
   output logic                      step_active,
   output logic                      upd_vld,
   output logic [CH_W-1:0]           upd_chan,
   output logic [WIPER_W-1:0]        upd_val
);
   generate
      if (WIPER_W < 2) begin : g_bad_width
         $error("wiper_step_ctrl: WIPER_W must be at least 2");
      end
      if (NUM_CH < 1) begin : g_bad_chan
         $error("wiper_step_ctrl: NUM_CH must be at least 1");
      end
   endgenerate

   logic               fire;
   step_dir_e          dir;
   logic [CH_W-1:0]    chan;
   logic [WIPER_W-1:0] cur_sel;

   wiper_step_seq #(.NUM_CH(NUM_CH)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_lvl(sda_lvl),
      .start_det(start_det), .stop_det(stop_det),
      .arm(arm), .arm_chan(arm_chan),
      .active(step_active), .chan(chan), .fire(fire), .dir(dir)
   );

   wiper_step_sel #(.WIPER_W(WIPER_W), .NUM_CH(NUM_CH)) u_sel (
      .wiper_all(wiper_all), .chan(chan), .cur_val(cur_sel)
   );

   wiper_step_calc #(.WIPER_W(WIPER_W), .NUM_CH(NUM_CH)) u_calc (
      .clk(clk), .rst_n(rst_n), .fire(fire), .dir(dir), .chan(chan),
      .cur_val(cur_sel),
      .upd_vld(upd_vld), .upd_chan(upd_chan), .upd_val(upd_val)
   );
endmodule

// File: rtl/wiper_step_chk.sv
module wiper_step_chk #(
   parameter int WIPER_W = 8,
   parameter int NUM_CH  = 4,
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               scl_fall,
   input logic               start_det,
   input logic               stop_det,
   input logic               arm,
   input logic               step_active,
   input logic               upd_vld,
   input logic [CH_W-1:0]    upd_chan,
   input logic [WIPER_W-1:0] upd_val,
   input logic [WIPER_W-1:0] cur_sel
);
   localparam logic [WIPER_W-1:0] TOP_VAL = {WIPER_W{1'b1}};

   a_r2_arm_enters: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !start_det && !stop_det) |=> step_active);

   a_r3_strobe_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld |-> $past(scl_fall));

   a_r3_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      upd_vld |=> !upd_vld);

   a_r5_no_wrap_top: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_vld && $past(cur_sel) == TOP_VAL) |-> upd_val != '0);

   a_r5_no_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_vld && $past(cur_sel) == '0) |-> upd_val != TOP_VAL);

   a_r7_stop_exits: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !step_active);

   a_r8_start_exits: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !step_active);

   a_r9_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
      !step_active |=> !upd_vld);

   logic unused_chk;
   assign unused_chk = ^upd_chan;
endmodule

bind wiper_step_ctrl wiper_step_chk #(.WIPER_W(WIPER_W), .NUM_CH(NUM_CH)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall),
   .start_det(start_det), .stop_det(stop_det), .arm(arm),
   .step_active(step_active), .upd_vld(upd_vld), .upd_chan(upd_chan),
   .upd_val(upd_val), .cur_sel(cur_sel)
);

// File: tb/test_wiper_step_ctrl.sv
`timescale 1ns/1ps
module test_wiper_step_ctrl;
   localparam int W  = 8;
   localparam int NC = 4;
   localparam int CW = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_rise = 0, scl_fall = 0, sda_lvl = 0;
   logic start_det = 0, stop_det = 0, arm = 0;
   logic [CW-1:0] arm_chan = '0;
   logic [NC*W-1:0] wiper_all;
   logic step_active, upd_vld;
   logic [CW-1:0] upd_chan;
   logic [W-1:0] upd_val;

   int checks = 0;
   int fails = 0;
   int strobes = 0;

   logic [W-1:0] store [NC];
   logic [W-1:0] model [NC];
   logic [W+CW-1:0] exp_q [$];
   string req_q [$];

   always #2.5 clk = ~clk;

   wiper_step_ctrl #(.WIPER_W(W), .NUM_CH(NC)) i_wiper_step_ctrl (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .sda_lvl(sda_lvl), .start_det(start_det), .stop_det(stop_det),
      .arm(arm), .arm_chan(arm_chan), .wiper_all(wiper_all),
      .step_active(step_active), .upd_vld(upd_vld),
      .upd_chan(upd_chan), .upd_val(upd_val)
   );

   // external wiper storage
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         store[0] <= 8'h10; store[1] <= 8'hFE;
         store[2] <= 8'h01; store[3] <= 8'h80;
      end else if (upd_vld) begin
         store[upd_chan] <= upd_val;
      end
   end
   always_comb begin
      for (int i = 0; i < NC; i++) wiper_all[i*W +: W] = store[i];
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (act !== expv) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   // monitor: pops scoreboard on each strobe
   always @(negedge clk) begin
      if (rst_n && upd_vld) begin
         strobes++;
         checks++;
         if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R9 unexpected strobe actual=%0h expected=none", {upd_chan, upd_val});
         end else begin
            automatic logic [W+CW-1:0] e = exp_q.pop_front();
            automatic string r = req_q.pop_front();
            if ({upd_chan, upd_val} !== e) begin
               fails++;
               $display("FAIL %s actual=%0h expected=%0h", r, {upd_chan, upd_val}, e);
            end
         end
      end
   end

   task automatic strobe(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   // one SCL pulse; lvl at the rise, lvl_late during high; brk 1=START 2=STOP in the middle
   task automatic bus_pulse(input logic lvl, input logic lvl_late, input int ch,
                            input bit expect_upd, input int brk, input string req);
      @(negedge clk) begin sda_lvl = lvl; scl_rise = 1'b1; end
      @(negedge clk) begin scl_rise = 1'b0; sda_lvl = lvl_late; end
      @(negedge clk) begin
         if (brk == 1) start_det = 1'b1;
         if (brk == 2) stop_det = 1'b1;
      end
      @(negedge clk) begin
         start_det = 1'b0; stop_det = 1'b0;
         scl_fall = 1'b1;
         if (expect_upd) begin
            if (lvl) model[ch] = (model[ch] == 8'hFF) ? 8'hFF : model[ch] + 8'd1;
            else     model[ch] = (model[ch] == 8'h00) ? 8'h00 : model[ch] - 8'd1;
            exp_q.push_back({CW'(ch), model[ch]});
            req_q.push_back(req);
         end
      end
      @(negedge clk) scl_fall = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic arm_ch(input int ch);
      @(negedge clk) begin arm = 1'b1; arm_chan = CW'(ch); end
      @(negedge clk) arm = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      int s0;
      model[0] = 8'h10; model[1] = 8'hFE; model[2] = 8'h01; model[3] = 8'h80;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 step_active", step_active, 0);
      chk("R1 upd_vld", upd_vld, 0);

      // R9: pulses while idle
      bus_pulse(1, 1, 0, 0, 0, "R9");
      bus_pulse(0, 0, 0, 0, 0, "R9");
      chk("R9 idle strobes", strobes, 0);

      // R2 arm channel 0
      arm_ch(0);
      chk("R2 active after arm", step_active, 1);

      bus_pulse(1, 1, 0, 1, 0, "R3 up");
      bus_pulse(1, 1, 0, 1, 0, "R3 up");
      bus_pulse(0, 0, 0, 1, 0, "R4 down");
      bus_pulse(1, 0, 0, 1, 0, "R9 sda change after rise");
      bus_pulse(0, 1, 0, 1, 0, "R9 sda change after rise");

      // R7 stop
      strobe(stop_det);
      chk("R7 inactive after stop", step_active, 0);
      s0 = strobes;
      bus_pulse(1, 1, 0, 0, 0, "R7");
      chk("R7 no strobe after stop", strobes, s0);

      // R5/R6 channel 1 near top, mixed
      arm_ch(1);
      bus_pulse(1, 1, 1, 1, 0, "R5 up to top");
      bus_pulse(1, 1, 1, 1, 0, "R5 saturate top");
      bus_pulse(1, 1, 1, 1, 0, "R5 saturate top");
      bus_pulse(0, 0, 1, 1, 0, "R6 mixed down");
      bus_pulse(1, 1, 1, 1, 0, "R6 mixed up");

      // R8 START mid-pulse cancels step and exits
      s0 = strobes;
      bus_pulse(0, 0, 1, 0, 1, "R8");
      repeat (2) @(negedge clk);
      chk("R8 cancelled step", strobes, s0);
      chk("R8 inactive after start", step_active, 0);

      // R8 STOP mid-pulse cancels
      arm_ch(3);
      s0 = strobes;
      bus_pulse(1, 1, 3, 0, 2, "R8");
      chk("R8 stop mid pulse", strobes, s0);

      // R5 bottom saturation on channel 2
      arm_ch(2);
      bus_pulse(0, 0, 2, 1, 0, "R5 down to zero");
      bus_pulse(0, 0, 2, 1, 0, "R5 saturate zero");
      strobe(stop_det);

      repeat (4) @(negedge clk);
      chk("R6 scoreboard drained", exp_q.size(), 0);
      for (int i = 0; i < NC; i++) begin
         chk("R6 final wiper", store[i], model[i]);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule